// File: doc/BRIEF.md
# Stack Descriptor Displacement Unit

This block moves a stack by a signed distance in one step. The stack is described by a 64-bit doubleword. The doubleword holds a top-of-stack address, a count of free words still available, a count of words in use, and two flags that suppress the limit trap. A 16-bit two's-complement modifier is applied to all three numeric fields at once. It is added to the address, subtracted from the free count and added to the used count.

Both counts are checked against the range 0 to 32767. When both stay in range, the three new fields are committed together. When either leaves the range, the doubleword is returned unchanged and the operation aborts. An abort raises a trap request unless the flag for the faulting count suppresses it. In every case a 4-bit condition code reports the outcome.

The controller has three states:
- `ST_IDLE` waits for `start_i` and captures the operands (transition IDLE→EVAL).
- `ST_EVAL` registers the result and raises `done_o` (transition EVAL→REPORT).
- `ST_REPORT` lets the done pulse end (transition REPORT→IDLE).

Top module: `spdw_adjust`

## Requirements
- R1: With `ext_mode_i`=0, the address field is `dw[48:32]` (17 bits). It becomes (address + sign-extended modifier) mod 2^17, and `dw[51:49]` are passed through unchanged.
- R2: With `ext_mode_i`=1, the address field is `dw[51:32]` (20 bits). It becomes (address + sign-extended modifier) mod 2^20.
- R3: The free count in `dw[30:16]` is replaced by the free count minus the modifier.
- R4: The used count in `dw[14:0]` is replaced by the used count plus the modifier.
- R5: If either new count is below 0 or above 32767, the operation aborts and `dw_o` equals the captured input doubleword exactly. The limits 0 and 32767 themselves are valid results.
- R6: `trap_o`=1 exactly when the free count faults while `dw[31]`=0, or the used count faults while `dw[15]`=0. Bit 31 suppresses the trap for the free count and bit 15 suppresses it for the used count.
- R7: On an abort, `cc_o[3]` is the free-count fault, `cc_o[1]` is the used-count fault, `cc_o[2]` means the old free count is zero, and `cc_o[0]` means the old used count is zero.
- R8: On success, `cc_o[3]`=`cc_o[1]`=0, `cc_o[2]` means the new free count is zero, and `cc_o[0]` means the new used count is zero.
- R9: Bits `dw[63:52]` and both suppress flags are always passed through unchanged.
- R10: `start_i` is sampled at clock edge k. The outputs and `done_o`=1 appear after edge k+1, and `done_o` stays high for exactly one cycle. Between done pulses, `dw_o`, `cc_o` and `trap_o` hold their values.
- R11: `start_i` is ignored while an operation is in progress (in `ST_EVAL` or `ST_REPORT`).
- R12: During reset, `dw_o`, `cc_o`, `trap_o` and `done_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled in `ST_IDLE`) |
| dw_i | input | 64 | Current stack descriptor doubleword |
| mod_i | input | 16 | Signed displacement |
| ext_mode_i | input | 1 | 1 selects the 20-bit address field |
| dw_o | output | 64 | Updated (or unchanged) doubleword |
| cc_o | output | 4 | Condition code |
| trap_o | output | 1 | Stack-limit trap request |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Suppose an operand register is captured in the wrong state, or the controller skips `ST_EVAL`. Then `done_o` arrives one cycle early or late, or `dw_o` carries fields from the wrong operation, and this shows at the first done pulse after the fault.

A wrong fault decision is visible in the same pulse. A doubleword that changes on an abort, or stays the same on a success, is one sign. A condition code whose fault bits disagree with `trap_o` and the suppress flags is another. The directed tests hit each count limit exactly, cross both address widths, and restart while the unit is busy, so each of these faults shows within one operation.

// File: rtl/spdw_pkg.sv
package spdw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVAL   = 2'd1,
        ST_REPORT = 2'd2
    } state_t;

    // condition code bit positions
    localparam int CC_SPACE_FLT  = 3;
    localparam int CC_SPACE_ZERO = 2;
    localparam int CC_WORD_FLT   = 1;
    localparam int CC_WORD_ZERO  = 0;

endpackage

// File: rtl/spdw_range_unit.sv
// Applies the modifier to one count at two extra bits of signed precision
// and flags results outside 0 .. 2**CNT_W-1.
module spdw_range_unit #(
    parameter int CNT_W    = 15,
    parameter int MOD_W    = 16,
    parameter bit SUBTRACT = 1'b0
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [MOD_W-1:0] mod_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fault_o,
    output logic             old_zero_o,
    output logic             new_zero_o
);
    localparam int EXT_W = CNT_W + 2;

    logic signed [EXT_W-1:0] base_s;
    logic signed [EXT_W-1:0] mod_s;
    logic signed [EXT_W-1:0] res_s;

    assign base_s = {2'b00, cnt_i};
    assign mod_s  = {{(EXT_W-MOD_W){mod_i[MOD_W-1]}}, mod_i};

    generate
        if (SUBTRACT) begin : g_sub
            assign res_s = base_s - mod_s;
        end else begin : g_add
            assign res_s = base_s + mod_s;
        end
    endgenerate

    // negative result sets the sign bit; too large sets the bit above the count
    assign fault_o    = res_s[EXT_W-1] | res_s[EXT_W-2];
    assign cnt_o      = res_s[CNT_W-1:0];
    assign old_zero_o = (cnt_i == '0);
    assign new_zero_o = (cnt_o == '0);

endmodule

// File: rtl/spdw_addr_unit.sv
// Adds the modifier to the top-of-stack address in either field width.
module spdw_addr_unit #(
    parameter int ADDR_NW = 17,
    parameter int ADDR_XW = 20,
    parameter int MOD_W   = 16
) (
    input  logic [ADDR_XW-1:0] addr_i,
    input  logic [MOD_W-1:0]   mod_i,
    input  logic               ext_i,
    output logic [ADDR_XW-1:0] addr_o
);
    logic [ADDR_XW-1:0] mod_x;
    logic [ADDR_XW-1:0] sum_x;
    logic [ADDR_NW-1:0] sum_n;

    assign mod_x = {{(ADDR_XW-MOD_W){mod_i[MOD_W-1]}}, mod_i};
    assign sum_x = addr_i + mod_x;
    assign sum_n = addr_i[ADDR_NW-1:0] + mod_x[ADDR_NW-1:0];

    always_comb begin
        if (ext_i) begin
            addr_o = sum_x;
        end else begin
            addr_o = {addr_i[ADDR_XW-1:ADDR_NW], sum_n};
        end
    end

endmodule

// File: rtl/spdw_adjust.sv
module spdw_adjust
    import spdw_pkg::*;
#(
    parameter int DW_W    = 64,
    parameter int CNT_W   = 15,
    parameter int MOD_W   = 16,
    parameter int ADDR_NW = 17,
    parameter int ADDR_XW = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [DW_W-1:0] dw_i,
    input  logic [MOD_W-1:0] mod_i,
    input  logic            ext_mode_i,
    output logic [DW_W-1:0] dw_o,
    output logic [3:0]      cc_o,
    output logic            trap_o,
    output logic            done_o
);
    localparam int WORD_LSB  = 0;
    localparam int WINH_BIT  = CNT_W;
    localparam int SPACE_LSB = CNT_W + 1;
    localparam int SINH_BIT  = 2 * CNT_W + 1;
    localparam int ADDR_LSB  = 2 * CNT_W + 2;

    state_t state_q, state_d;

    logic [DW_W-1:0]  op_dw_q;
    logic [MOD_W-1:0] op_mod_q;
    logic             op_ext_q;

    logic [DW_W-1:0] dw_q;
    logic [3:0]      cc_q;
    logic            trap_q;
    logic            done_q;

    logic [CNT_W-1:0]   space_new, word_new;
    logic               space_flt, word_flt;
    logic               space_old_z, word_old_z;
    logic               space_new_z, word_new_z;
    logic [ADDR_XW-1:0] addr_new;
    logic               abort;
    logic [DW_W-1:0]    commit_dw;
    logic [3:0]         cc_d;
    logic               trap_d;

    spdw_range_unit #(.CNT_W(CNT_W), .MOD_W(MOD_W), .SUBTRACT(1'b1)) u_space (
        .cnt_i      (op_dw_q[SPACE_LSB +: CNT_W]),
        .mod_i      (op_mod_q),
        .cnt_o      (space_new),
        .fault_o    (space_flt),
        .old_zero_o (space_old_z),
        .new_zero_o (space_new_z)
    );

    spdw_range_unit #(.CNT_W(CNT_W), .MOD_W(MOD_W), .SUBTRACT(1'b0)) u_word (
        .cnt_i      (op_dw_q[WORD_LSB +: CNT_W]),
        .mod_i      (op_mod_q),
        .cnt_o      (word_new),
        .fault_o    (word_flt),
        .old_zero_o (word_old_z),
        .new_zero_o (word_new_z)
    );

    spdw_addr_unit #(.ADDR_NW(ADDR_NW), .ADDR_XW(ADDR_XW), .MOD_W(MOD_W)) u_addr (
        .addr_i (op_dw_q[ADDR_LSB +: ADDR_XW]),
        .mod_i  (op_mod_q),
        .ext_i  (op_ext_q),
        .addr_o (addr_new)
    );

    // result decision
    always_comb begin
        abort     = space_flt | word_flt;
        commit_dw = op_dw_q;
        commit_dw[ADDR_LSB  +: ADDR_XW] = addr_new;
        commit_dw[SPACE_LSB +: CNT_W]   = space_new;
        commit_dw[WORD_LSB  +: CNT_W]   = word_new;
        cc_d = '0;
        if (abort) begin
            cc_d[CC_SPACE_FLT]  = space_flt;
            cc_d[CC_WORD_FLT]   = word_flt;
            cc_d[CC_SPACE_ZERO] = space_old_z;
            cc_d[CC_WORD_ZERO]  = word_old_z;
        end else begin
            cc_d[CC_SPACE_ZERO] = space_new_z;
            cc_d[CC_WORD_ZERO]  = word_new_z;
        end
        trap_d = (space_flt & ~op_dw_q[SINH_BIT]) | (word_flt & ~op_dw_q[WINH_BIT]);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_EVAL;
            ST_EVAL:   state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // operands and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_dw_q  <= '0;
            op_mod_q <= '0;
            op_ext_q <= 1'b0;
            dw_q     <= '0;
            cc_q     <= '0;
            trap_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        op_dw_q  <= dw_i;
                        op_mod_q <= mod_i;
                        op_ext_q <= ext_mode_i;
                    end
                end
                ST_EVAL: begin
                    done_q <= 1'b1;
                    cc_q   <= cc_d;
                    trap_q <= trap_d;
                    dw_q   <= abort ? op_dw_q : commit_dw;
                end
                ST_REPORT: begin
                    done_q <= 1'b0;
                end
                default: begin
                    done_q <= 1'b0;
                end
            endcase
        end
    end

    assign dw_o   = dw_q;
    assign cc_o   = cc_q;
    assign trap_o = trap_q;
    assign done_o = done_q;

endmodule

// File: rtl/spdw_adjust_chk.sv
module spdw_adjust_chk
    import spdw_pkg::*;
#(
    parameter int DW_W    = 64,
    parameter int CNT_W   = 15,
    parameter int ADDR_XW = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [DW_W-1:0] dw_i,
    input state_t          state_i,
    input logic [DW_W-1:0] dw_o,
    input logic [3:0]      cc_o,
    input logic            trap_o,
    input logic            done_o
);
    localparam int WINH_BIT  = CNT_W;
    localparam int SPACE_LSB = CNT_W + 1;
    localparam int SINH_BIT  = 2 * CNT_W + 1;
    localparam int HI_LSB    = 2 * CNT_W + 2 + ADDR_XW;

    logic [DW_W-1:0] cap_dw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_dw <= '0;
        end else if (start_i && state_i == ST_IDLE) begin
            cap_dw <= dw_i;
        end
    end

    p_done_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_eval_gives_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_EVAL) |=> done_o);

    p_hold_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(dw_o) && $stable(cc_o) && $stable(trap_o)));

    p_abort_unchanged_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (cc_o[CC_SPACE_FLT] || cc_o[CC_WORD_FLT])) |-> (dw_o == cap_dw));

    p_trap_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && trap_o) |->
            ((cc_o[CC_SPACE_FLT] && !cap_dw[SINH_BIT]) ||
             (cc_o[CC_WORD_FLT] && !cap_dw[WINH_BIT])));

    p_keep_fixed_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((dw_o[DW_W-1:HI_LSB] == cap_dw[DW_W-1:HI_LSB]) &&
                    (dw_o[SINH_BIT] == cap_dw[SINH_BIT]) &&
                    (dw_o[WINH_BIT] == cap_dw[WINH_BIT])));

    p_success_zero_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cc_o[CC_SPACE_FLT] && !cc_o[CC_WORD_FLT]) |->
            ((cc_o[CC_SPACE_ZERO] == (dw_o[SPACE_LSB +: CNT_W] == '0)) &&
             (cc_o[CC_WORD_ZERO]  == (dw_o[0 +: CNT_W] == '0)) && !trap_o));

endmodule

bind spdw_adjust spdw_adjust_chk #(
    .DW_W    (DW_W),
    .CNT_W   (CNT_W),
    .ADDR_XW (ADDR_XW)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .dw_i    (dw_i),
    .state_i (state_q),
    .dw_o    (dw_o),
    .cc_o    (cc_o),
    .trap_o  (trap_o),
    .done_o  (done_o)
);

// File: tb/spdw_adjust_tb_top.sv
module spdw_adjust_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] dw_i = '0;
    logic [15:0] mod_i = '0;
    logic        ext_mode_i = 1'b0;
    logic [63:0] dw_o;
    logic [3:0]  cc_o;
    logic        trap_o;
    logic        done_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    spdw_adjust dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .dw_i       (dw_i),
        .mod_i      (mod_i),
        .ext_mode_i (ext_mode_i),
        .dw_o       (dw_o),
        .cc_o       (cc_o),
        .trap_o     (trap_o),
        .done_o     (done_o)
    );

    function automatic logic [63:0] mk(input logic [11:0] hi, input logic [19:0] addr,
                                       input logic ts, input int sp,
                                       input logic tw, input int wd);
        logic [14:0] s15;
        logic [14:0] w15;
        s15 = sp[14:0];
        w15 = wd[14:0];
        return {hi, addr, ts, s15, tw, w15};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // expected result computed from the requirements
    task automatic model(input logic [63:0] d, input logic [15:0] m, input logic e,
                         output logic [63:0] nd, output logic [3:0] c, output logic t);
        int mv, sp, wd, nsp, nwd, a;
        bit sf, wf;
        mv  = int'($signed(m));
        sp  = int'(d[30:16]);
        wd  = int'(d[14:0]);
        nsp = sp - mv;
        nwd = wd + mv;
        sf  = (nsp < 0) || (nsp > 32767);
        wf  = (nwd < 0) || (nwd > 32767);
        nd  = d;
        if (sf || wf) begin
            c = {sf, sp == 0, wf, wd == 0};
            t = (sf && !d[31]) || (wf && !d[15]);
        end else begin
            if (e) begin
                a = int'(d[51:32]) + mv;
                nd[51:32] = a[19:0];
            end else begin
                a = int'(d[48:32]) + mv;
                nd[48:32] = a[16:0];
            end
            nd[30:16] = nsp[14:0];
            nd[14:0]  = nwd[14:0];
            c = {1'b0, nsp == 0, 1'b0, nwd == 0};
            t = 1'b0;
        end
    endtask

    task automatic run_op(input string req, input logic [63:0] d,
                          input logic [15:0] m, input logic e);
        logic [63:0] nd;
        logic [3:0]  c;
        logic        t;
        model(d, m, e, nd, c, t);
        @(negedge clk);
        start_i = 1'b1; dw_i = d; mod_i = m; ext_mode_i = e;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        check(req, "done", {63'd0, done_o}, 64'd1);
        check(req, "dw", dw_o, nd);
        check(req, "cc", {60'd0, cc_o}, {60'd0, c});
        check(req, "trap", {63'd0, trap_o}, {63'd0, t});
        @(negedge clk);
        check("R10", "done drop", {63'd0, done_o}, 64'd0);
        check("R10", "dw hold", dw_o, nd);
    endtask

    task automatic t_reset();
        check("R12", "reset dw", dw_o, 64'd0);
        check("R12", "reset cc", {60'd0, cc_o}, 64'd0);
        check("R12", "reset trap/done", {62'd0, trap_o, done_o}, 64'd0);
    endtask

    task automatic t_basic();
        run_op("R3 R4 R8", mk(12'hABC, 20'h00100, 1'b0, 100, 1'b0, 5), 16'd10, 1'b0);
        check("R1", "hand value", dw_o, mk(12'hABC, 20'h0010A, 1'b0, 90, 1'b0, 15));
        check("R8", "hand cc", {60'd0, cc_o}, 64'd0);
    endtask

    task automatic t_negative();
        run_op("R1", mk(12'h123, 20'h00005, 1'b1, 50, 1'b1, 40), 16'hFFEC, 1'b0);
        check("R1", "neg wrap", {44'd0, dw_o[51:32]}, 64'h1FFF1);
    endtask

    task automatic t_narrow_wrap();
        run_op("R1 R9", mk(12'hF0F, 20'hBFFFF, 1'b0, 200, 1'b0, 20), 16'd1, 1'b0);
        check("R1", "narrow carry kept", {44'd0, dw_o[51:32]}, 64'hA0000);
    endtask

    task automatic t_ext();
        run_op("R2", mk(12'h055, 20'hBFFFF, 1'b0, 200, 1'b0, 20), 16'd1, 1'b1);
        check("R2", "ext carry", {44'd0, dw_o[51:32]}, 64'hC0000);
        run_op("R2", mk(12'h000, 20'hFFFFF, 1'b0, 200, 1'b0, 20), 16'd2, 1'b1);
        check("R2", "ext wrap", {44'd0, dw_o[51:32]}, 64'h00001);
    endtask

    task automatic t_limits();
        run_op("R5 R8", mk(12'h001, 20'h00400, 1'b0, 7, 1'b0, 32760), 16'd7, 1'b0);
        check("R8", "space zero cc", {60'd0, cc_o}, 64'h4);
        run_op("R4 R8", mk(12'h002, 20'h00400, 1'b0, 10, 1'b0, 3), 16'hFFFD, 1'b0);
        check("R8", "word zero cc", {60'd0, cc_o}, 64'h1);
    endtask

    task automatic t_space_fault();
        run_op("R5 R6 R7", mk(12'h003, 20'h00020, 1'b0, 5, 1'b0, 10), 16'd6, 1'b0);
        check("R6", "space trap", {63'd0, trap_o}, 64'd1);
        run_op("R6 R7", mk(12'h003, 20'h00020, 1'b1, 5, 1'b0, 10), 16'd6, 1'b0);
        check("R7", "space cc inhibited", {60'd0, cc_o}, 64'h8);
    endtask

    task automatic t_word_fault();
        run_op("R5 R6", mk(12'h004, 20'h00030, 1'b0, 100, 1'b0, 32767), 16'd1, 1'b0);
        check("R6", "word trap", {63'd0, trap_o}, 64'd1);
        run_op("R7", mk(12'h004, 20'h00030, 1'b0, 100, 1'b1, 32767), 16'd1, 1'b0);
        check("R7", "word cc inhibited", {61'd0, cc_o[3:0] == 4'h2, trap_o, 1'b0}, 64'h4);
    endtask

    task automatic t_both_fault();
        run_op("R6 R7", mk(12'h005, 20'h00040, 1'b1, 0, 1'b0, 100), 16'h8000, 1'b0);
        check("R6", "word side traps", {63'd0, trap_o}, 64'd1);
        run_op("R6 R7", mk(12'h005, 20'h00040, 1'b1, 0, 1'b1, 100), 16'h8000, 1'b0);
        check("R7", "both cc", {60'd0, cc_o}, 64'hE);
    endtask

    task automatic t_busy();
        logic [63:0] d1, d2, nd;
        logic [3:0]  c;
        logic        t;
        d1 = mk(12'h00A, 20'h00100, 1'b0, 300, 1'b0, 30);
        d2 = mk(12'h00B, 20'h00200, 1'b0, 1, 1'b0, 1);
        model(d1, 16'd20, 1'b0, nd, c, t);
        @(negedge clk);
        start_i = 1'b1; dw_i = d1; mod_i = 16'd20; ext_mode_i = 1'b0;
        @(negedge clk);
        dw_i = d2; mod_i = 16'd5;
        @(negedge clk);
        check("R11", "first result kept", dw_o, nd);
        check("R11", "done", {63'd0, done_o}, 64'd1);
        start_i = 1'b0;
        @(negedge clk);
        check("R11", "no second done", {63'd0, done_o}, 64'd0);
        @(negedge clk);
        check("R11", "still idle", {63'd0, done_o}, 64'd0);
        check("R11", "result unchanged", dw_o, nd);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_negative();
        t_narrow_wrap();
        t_ext();
        t_limits();
        t_space_fault();
        t_word_fault();
        t_both_fault();
        t_busy();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule